// File: doc/BRIEF.md
# Dual Circular-Buffer Address Generator

This block produces data-memory addresses for two memories, X and Y, in the same clock cycle. It holds one generator per memory. Each generator has a small set of pointers, and every pointer has three registers: an index, a signed step and a span. When an access names a pointer, the pointer's current index is presented as the address in that same cycle. On the following clock edge the index advances by its step.

A span of zero gives plain linear stepping, which wraps modulo 2^AW. A non-zero span L confines the pointer to a window of L words. The window starts at the index rounded down to a multiple of L. That window base is taken whenever the index or the span register is written. If a step would leave the window, L is added or subtracted to bring the pointer back inside.

All three register kinds are loaded through one shared load port. The load port carries a register kind, a global pointer number and a value. The instruction decoder and the memory arrays sit outside this block.

Top module: `dual_agu`

## Requirements
- R1: After a synchronous active-low reset, every index, step and span register is zero, so both address outputs read 0 for every pointer select.
- R2: While a generator's access input is high, its address output equals the current index of the selected pointer in the same cycle, with no register in between.
- R3: With span zero, an access sets the selected index on the next edge to (index + step) modulo 2^AW.
- R4: With span L non-zero, the window base is the index rounded down to a multiple of L, captured when the index or the span is written. The index after an access is base + ((index − base + step) mod L). Steps are assumed to satisfy |step| < L.
- R5: The step register is two's complement, so a negative step moves the pointer backward, both linearly and with wrap-around.
- R6: Global pointer numbers 0 to NPTR−1 address generator X and NPTR to 2·NPTR−1 address generator Y. The most significant bit of the load pointer number selects the generator. Both generators issue and step independently in the same cycle.
- R7: The load kind field encodes 00 = index, 01 = step, 10 = span. A load takes effect on the next edge.
- R8: Load kind 11 changes no register.
- R9: A pointer that is neither accessed nor index-loaded keeps its index.
- R10: If an index load and an access hit the same pointer in one cycle, the address in that cycle is the old index. The next cycle shows the loaded value, with no step applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| x_acc | input | 1 | Access on memory X this cycle |
| x_sel | input | $clog2(NPTR) | Pointer used by the X access |
| x_addr | output | AW | Address for memory X |
| y_acc | input | 1 | Access on memory Y this cycle |
| y_sel | input | $clog2(NPTR) | Pointer used by the Y access |
| y_addr | output | AW | Address for memory Y |
| ld_en | input | 1 | Register load strobe |
| ld_kind | input | 2 | Register kind being loaded |
| ld_ptr | input | $clog2(NPTR)+1 | Global pointer number |
| ld_data | input | AW | Value to load |

## Verification
The bench builds the block with AW = 8 and NPTR = 4. With these values, linear wrap past 255 and through zero takes only a few steps. The circular sweep covers every span from 1 to 12 combined with every legal step from −(L−1) to L−1, running both generators in the same cycles. Pointers and windows are small enough that each window is traversed more than once, so every wrap in both directions is observed.

// File: rtl/agu_pkg.sv
// Package: shared encodings for the dual address generator.
// Assumes: nothing beyond the 2-bit load-kind field.
package agu_pkg;
    typedef enum logic [1:0] {
        LD_INDEX = 2'b00,
        LD_STEP  = 2'b01,
        LD_SPAN  = 2'b10,
        LD_NONE  = 2'b11
    } ld_kind_e;
endpackage

// File: rtl/agu_step.sv
// agu_step: combinational next-index unit. It adds a signed step and, when
// the span is non-zero, folds the sum back into [base, base+span-1].
// Assumes: |step| < span whenever span is non-zero, and cur lies in the window.
module agu_step #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] step,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] span,
    output logic [AW-1:0] nxt
);
    localparam int EW = AW + 2;

    logic signed [EW-1:0] sum;
    logic signed [EW-1:0] lo;
    logic signed [EW-1:0] hi;
    logic signed [EW-1:0] fold;

    // Wide signed arithmetic so that window compares never overflow
    always_comb begin
        sum  = $signed({2'b00, cur}) + $signed({{2{step[AW-1]}}, step});
        lo   = $signed({2'b00, base});
        hi   = lo + $signed({2'b00, span});
        fold = sum;
        if (span != '0) begin
            if (sum >= hi)
                fold = sum - $signed({2'b00, span});
            else if (sum < lo)
                fold = sum + $signed({2'b00, span});
        end
        nxt = fold[AW-1:0];
    end
endmodule

// File: rtl/agu_bank.sv
// agu_bank: one generator. It holds NPTR pointers, each with an index, a
// step, a span and a captured window base. The selected index is presented
// as the address; on access that index post-steps through agu_step.
// Assumes: at most one load per cycle, arriving through wr_*.
module agu_bank
    import agu_pkg::*;
#(
    parameter int AW   = 16,
    parameter int NPTR = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc,
    input  logic [$clog2(NPTR)-1:0] sel,
    output logic [AW-1:0]           addr,
    input  logic                    wr_en,
    input  logic [1:0]              wr_kind,
    input  logic [$clog2(NPTR)-1:0] wr_ptr,
    input  logic [AW-1:0]           wr_data
);
    localparam int SW = $clog2(NPTR);

    logic [AW-1:0] idx_q  [NPTR];
    logic [AW-1:0] mod_q  [NPTR];
    logic [AW-1:0] len_q  [NPTR];
    logic [AW-1:0] base_q [NPTR];

    logic [NPTR-1:0] wr_idx, wr_mod, wr_len, hit;
    logic [AW-1:0]   step_nxt, seed_idx, seed_len, seed_base;
    ld_kind_e        kind;

    assign kind = ld_kind_e'(wr_kind);
    assign addr = idx_q[sel];

    agu_step #(.AW(AW)) u_step (
        .cur  (idx_q[sel]),
        .step (mod_q[sel]),
        .base (base_q[sel]),
        .span (len_q[sel]),
        .nxt  (step_nxt)
    );

    // Decode the load and the access into per-pointer strobes
    always_comb begin
        for (int k = 0; k < NPTR; k++) begin
            wr_idx[k] = wr_en && (kind == LD_INDEX) && (wr_ptr == SW'(k));
            wr_mod[k] = wr_en && (kind == LD_STEP)  && (wr_ptr == SW'(k));
            wr_len[k] = wr_en && (kind == LD_SPAN)  && (wr_ptr == SW'(k));
            hit[k]    = acc && (sel == SW'(k));
        end
    end

    // Window base for the pointer being loaded: index rounded down to a multiple of span
    always_comb begin
        seed_idx  = (kind == LD_INDEX) ? wr_data : idx_q[wr_ptr];
        seed_len  = (kind == LD_SPAN)  ? wr_data : len_q[wr_ptr];
        seed_base = '0;
        if (seed_len != '0)
            seed_base = seed_idx - (seed_idx % seed_len);
    end

    // Register update: an index load wins over the post-step
    always_ff @(posedge clk) begin
        for (int k = 0; k < NPTR; k++) begin
            if (!rst_n) begin
                idx_q[k]  <= '0;
                mod_q[k]  <= '0;
                len_q[k]  <= '0;
                base_q[k] <= '0;
            end else begin
                if (wr_idx[k])
                    idx_q[k] <= wr_data;
                else if (hit[k])
                    idx_q[k] <= step_nxt;
                if (wr_mod[k])
                    mod_q[k] <= wr_data;
                if (wr_len[k])
                    len_q[k] <= wr_data;
                if (wr_idx[k] || wr_len[k])
                    base_q[k] <= seed_base;
            end
        end
    end

    for (genvar k = 0; k < NPTR; k++) begin : g_chk
        // R9
        idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!hit[k] && !wr_idx[k]) |=> $stable(idx_q[k]));
        // R3
        linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[k] && len_q[k] == '0 && !wr_idx[k] && !wr_len[k])
            |=> idx_q[k] == $past(idx_q[k] + mod_q[k]));
        // R4
        in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[k] && len_q[k] != '0 && !wr_idx[k] && !wr_len[k])
            |=> ({1'b0, idx_q[k]} >= {1'b0, base_q[k]}) &&
                ({1'b0, idx_q[k]} <  {1'b0, base_q[k]} + {1'b0, len_q[k]}));
        // R10
        load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_idx[k] |=> idx_q[k] == $past(wr_data));
    end
endmodule

// File: rtl/dual_agu.sv
// dual_agu: two independent generators, X and Y, sharing one load port.
// The top bit of ld_ptr picks the generator and the low bits pick the pointer.
// Assumes: the decoder issues at most one register load per cycle.
module dual_agu #(
    parameter int AW   = 16,
    parameter int NPTR = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    x_acc,
    input  logic [$clog2(NPTR)-1:0] x_sel,
    output logic [AW-1:0]           x_addr,
    input  logic                    y_acc,
    input  logic [$clog2(NPTR)-1:0] y_sel,
    output logic [AW-1:0]           y_addr,
    input  logic                    ld_en,
    input  logic [1:0]              ld_kind,
    input  logic [$clog2(NPTR):0]   ld_ptr,
    input  logic [AW-1:0]           ld_data
);
    localparam int SW  = $clog2(NPTR);
    localparam int NGEN = 2;

    logic          acc_a  [NGEN];
    logic [SW-1:0] sel_a  [NGEN];
    logic [AW-1:0] addr_a [NGEN];

    // Gather per-generator access inputs into arrays
    always_comb begin
        acc_a[0] = x_acc;
        sel_a[0] = x_sel;
        acc_a[1] = y_acc;
        sel_a[1] = y_sel;
    end

    assign x_addr = addr_a[0];
    assign y_addr = addr_a[1];

    for (genvar g = 0; g < NGEN; g++) begin : g_gen
        agu_bank #(.AW(AW), .NPTR(NPTR)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .acc     (acc_a[g]),
            .sel     (sel_a[g]),
            .addr    (addr_a[g]),
            .wr_en   (ld_en && (ld_ptr[SW] == 1'(g))),
            .wr_kind (ld_kind),
            .wr_ptr  (ld_ptr[SW-1:0]),
            .wr_data (ld_data)
        );
    end
endmodule

// File: tb/dual_agu_test.sv
module dual_agu_test;
    localparam int AW = 8;
    localparam int NPTR = 4;
    localparam int MSK = 255;

    logic clk = 0;
    logic rst_n = 0;
    logic x_acc = 0, y_acc = 0, ld_en = 0;
    logic [1:0] x_sel = 0, y_sel = 0, ld_kind = 0;
    logic [2:0] ld_ptr = 0;
    logic [7:0] ld_data = 0;
    logic [7:0] x_addr, y_addr;

    int checks = 0, errors = 0;
    int m_idx [2][4];
    int m_mod [2][4];
    int m_len [2][4];
    int m_base[2][4];

    always #10 clk = ~clk;

    dual_agu #(.AW(AW), .NPTR(NPTR)) uut (
        .clk(clk), .rst_n(rst_n),
        .x_acc(x_acc), .x_sel(x_sel), .x_addr(x_addr),
        .y_acc(y_acc), .y_sel(y_sel), .y_addr(y_addr),
        .ld_en(ld_en), .ld_kind(ld_kind), .ld_ptr(ld_ptr), .ld_data(ld_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int signed8(input int v);
        return (v & 128) ? (v & MSK) - 256 : (v & MSK);
    endfunction

    function automatic int next_idx(input int g, input int p);
        int s, off;
        s = signed8(m_mod[g][p]);
        if (m_len[g][p] == 0) return (m_idx[g][p] + s) & MSK;
        off = ((m_idx[g][p] - m_base[g][p] + s) % m_len[g][p] + m_len[g][p]) % m_len[g][p];
        return m_base[g][p] + off;
    endfunction

    // One cycle: drive at negedge, check addresses, clock, then update the model
    task automatic cyc(input bit xa, input int xs, input bit ya, input int ys,
                       input bit le, input int lk, input int lp, input int lv,
                       input string tag);
        int nx, ny, g, p;
        @(negedge clk);
        x_acc = xa; x_sel = 2'(xs); y_acc = ya; y_sel = 2'(ys);
        ld_en = le; ld_kind = 2'(lk); ld_ptr = 3'(lp); ld_data = 8'(lv);
        #2;
        chk(x_addr == 8'(m_idx[0][xs]), tag, x_addr, m_idx[0][xs]);
        chk(y_addr == 8'(m_idx[1][ys]), tag, y_addr, m_idx[1][ys]);
        nx = next_idx(0, xs);
        ny = next_idx(1, ys);
        @(posedge clk);
        if (xa) m_idx[0][xs] = nx;
        if (ya) m_idx[1][ys] = ny;
        if (le) begin
            g = lp / 4; p = lp % 4;
            if (lk == 0) begin
                m_idx[g][p] = lv & MSK;
                m_base[g][p] = (m_len[g][p] == 0) ? 0 : m_idx[g][p] - (m_idx[g][p] % m_len[g][p]);
            end else if (lk == 1) begin
                m_mod[g][p] = lv & MSK;
            end else if (lk == 2) begin
                m_len[g][p] = lv & MSK;
                m_base[g][p] = (m_len[g][p] == 0) ? 0 : m_idx[g][p] - (m_idx[g][p] % m_len[g][p]);
            end
        end
    endtask

    task automatic load(input int lk, input int lp, input int lv, input string tag);
        cyc(0, 0, 0, 0, 1, lk, lp, lv, tag);
    endtask

    initial begin
        #(20 * 200000);
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int mods[6];
        mods = '{1, 3, -1, -5, 127, -128};
        for (int g = 0; g < 2; g++)
            for (int p = 0; p < 4; p++) begin
                m_idx[g][p] = 0; m_mod[g][p] = 0; m_len[g][p] = 0; m_base[g][p] = 0;
            end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        // R1: reset state on every pointer select
        for (int p = 0; p < 4; p++) cyc(0, p, 0, p, 0, 0, 0, 0, "R1 reset");

        // R3 R5 R2: linear stepping, both directions, through the 8-bit wrap
        for (int m = 0; m < 6; m++) begin
            load(0, 1, 250, "R7 index load");
            load(1, 1, mods[m], "R7 step load");
            load(0, 6, 5, "R6 Y index load");
            load(1, 6, -mods[m], "R6 Y step load");
            for (int i = 0; i < 6; i++) cyc(1, 1, 1, 2, 0, 0, 0, 0, "R3 R5 R2 linear");
        end

        // R4 R5 R6: every span 1..12 with every legal step, both generators in parallel
        for (int L = 1; L <= 12; L++)
            for (int s = -(L - 1); s <= L - 1; s++) begin
                load(0, L % 4, 37, "R4 index");
                load(2, L % 4, L, "R4 span");
                load(1, L % 4, s, "R4 step");
                load(0, 4 + (L + 1) % 4, 200, "R6 index");
                load(2, 4 + (L + 1) % 4, L, "R6 span");
                load(1, 4 + (L + 1) % 4, -s, "R6 step");
                for (int i = 0; i < L + 2; i++)
                    cyc(1, L % 4, 1, (L + 1) % 4, 0, 0, 0, 0, "R4 R5 R6 circular");
            end

        // R10: index load and access collide on the same pointer
        load(2, 3, 0, "R10 span clear");
        load(1, 3, 4, "R10 step");
        load(0, 3, 10, "R10 index");
        cyc(1, 3, 0, 0, 1, 0, 3, 90, "R10 collide");
        cyc(1, 3, 0, 0, 0, 0, 0, 0, "R10 loaded value no step");
        cyc(0, 3, 0, 0, 0, 0, 0, 0, "R10 after step");

        // R8: kind 11 is ignored; observe indexes and subsequent stepping
        cyc(0, 3, 0, 0, 1, 3, 3, 77, "R8 ignored kind");
        cyc(1, 3, 0, 0, 1, 3, 7, 77, "R8 ignored kind Y");
        cyc(1, 3, 1, 3, 0, 0, 0, 0, "R8 no effect");

        // R9: idle pointers hold
        for (int i = 0; i < 4; i++) cyc(0, i, 0, i, 0, 0, 0, 0, "R9 hold");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule